// File: doc/BRIEF.md
# Interrupt Identification Register with Read Freeze

This block keeps the eight interrupt flags of a small radio baseband controller and shows them to a microcontroller as one read-only byte. Each source reports through one input bit. Seven of the bits are event pulses. Bit 7 is the chip-select status level, and only its falling edge counts as an event. A per-source enable mask, sampled in the cycle the event occurs, decides whether the event sets its sticky flag. No global interrupt enable takes part in this decision.

While the bus holds `rd_active_i` high for a read, the visible byte is frozen. Events that arrive during that window go into a pending store. When the strobe falls, the flags seen by the read are cleared, and the pending bits, together with any event in that same cycle, become the new visible flags. No event is lost, and no event is cleared before a read has shown it. The request output `irq_o` is high while any visible flag is set.

Top module: `irq_flag_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `flags_o` is 0x00 and `irq_o` is 0. The pending store is empty.
- R2: Flag bit n is set only by source input bit n. The bit order is: 0 lock-in, 1 lock-out, 2 link discharge, 3 receive overflow, 4 transmit empty, 5 receive almost-full, 6 transmit almost-empty, 7 chip-select. For sources 0 to 6, a 1 on the input in a cycle counts as an event.
- R3: An event sets its flag only if the matching bit of `src_en_i` is 1 in the same cycle. An event from a disabled source leaves its flag at 0.
- R4: While `rd_active_i` is 1, `flags_o` does not change. Enabled events in that window are recorded in the pending store, and no pending bit is dropped.
- R5: Outside a read and outside the cycle in which a read ends, a set flag stays set.
- R6: In the first cycle with `rd_active_i` low after it was high, the flags become the pending bits OR'd with that cycle's enabled events. The flags visible before that cycle are cleared, and the pending store is emptied. The new value is visible from the next cycle.
- R7: The chip-select flag (bit 7) is set only on a 1-to-0 transition of input bit 7. A rising edge or a steady level sets nothing.
- R8: `irq_o` is the OR of the visible flags. After a clearing read that has no pending bits and no same-cycle events, `irq_o` is 0 from the cycle after the strobe falls.
- R9: Clearing an enable bit after its flag is set does not clear that flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 8 | Source inputs: bits 0-6 are event pulses, bit 7 is the chip-select level |
| src_en_i | input | 8 | Per-source enable mask |
| rd_active_i | input | 1 | High while the microcontroller reads the register |
| flags_o | output | 8 | Visible interrupt flags |
| irq_o | output | 1 | Interrupt request, the OR of the flags |

## Verification
On every cycle, assertions check that the flags stay frozen and pending bits are kept during a read, and that flags stay sticky between reads. They also check that a flag can rise only when its enable was set, that the pending store is empty after a read ends, and that a chip-select event always comes from a real 1-to-0 transition. Only the bench scenarios can show the exact merged value after a read. The same holds for the bit-to-source order, for events that coincide with the end of the strobe, for a flag surviving a later disable, and for the request line dropping after a clearing read.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int unsigned IRQ_SRC_N     = 8;
    localparam int unsigned IRQ_LOCK_IN   = 0;
    localparam int unsigned IRQ_LOCK_OUT  = 1;
    localparam int unsigned IRQ_LINK_DIS  = 2;
    localparam int unsigned IRQ_RX_OVF    = 3;
    localparam int unsigned IRQ_TX_EMPTY  = 4;
    localparam int unsigned IRQ_RX_AFULL  = 5;
    localparam int unsigned IRQ_TX_AEMPTY = 6;
    localparam int unsigned IRQ_CHIP_SEL  = 7;
    // sources whose input is a level and whose event is a 1-to-0 transition
    localparam logic [IRQ_SRC_N-1:0] IRQ_FALL_MASK = 8'h80;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
    parameter int unsigned            NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0]     EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] evt_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_fall
            logic prev_d, prev_q;

            always_comb begin
                prev_d = src_i[i];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end

            assign evt_o[i] = prev_q & ~src_i[i];

            // R7: a level-source event only on a genuine 1-to-0 transition
            p_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                evt_o[i] |-> ($past(src_i[i]) && !src_i[i]));
        end else begin : g_pulse
            assign evt_o[i] = src_i[i];
        end
    end
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rd_active_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               rd_done_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] vis;
        logic [NUM_SRC-1:0] pend;
        logic               rd;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     rd_done;

    assign rd_done = st_q.rd & ~rd_active_i;

    always_comb begin
        st_d    = st_q;
        st_d.rd = rd_active_i;
        if (rd_active_i) begin
            st_d.pend = st_q.pend | evt_i;
        end else if (st_q.rd) begin
            st_d.vis  = st_q.pend | evt_i;
            st_d.pend = '0;
        end else begin
            st_d.vis = st_q.vis | evt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o   = st_q.vis;
    assign rd_done_o = rd_done;

    // R4: visible flags frozen during a read
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active_i |=> $stable(st_q.vis));

    // R4: no pending bit is lost while the read lasts
    p_pend_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active_i |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)));

    // R5: sticky outside reads
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active_i && !rd_done) |=> ((st_q.vis & $past(st_q.vis)) == $past(st_q.vis)));

    // R6: the pending store is drained when the read ends
    p_pend_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (st_q.pend == '0));

    // R6: a read with nothing pending and no new event leaves the flags clear
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && evt_i == '0 && st_q.pend == '0) |=> (st_q.vis == '0));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int unsigned                NUM_SRC   = IRQ_SRC_N,
    parameter logic [NUM_SRC-1:0]         EDGE_MASK = IRQ_FALL_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               rd_active_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] raw_evt;
    logic [NUM_SRC-1:0] gated_evt;
    logic               rd_done;

    irq_src_cond #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .evt_o (raw_evt)
    );

    always_comb begin
        gated_evt = raw_evt & src_en_i;
    end

    irq_flag_core #(
        .NUM_SRC (NUM_SRC)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (gated_evt),
        .rd_active_i (rd_active_i),
        .flags_o     (flags_o),
        .rd_done_o   (rd_done)
    );

    assign irq_o = |flags_o;

    // R3: outside a read, a flag rises only for a source enabled at that moment
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active_i && !rd_done) |=>
            ((flags_o & ~$past(flags_o) & ~$past(src_en_i)) == '0));
endmodule

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    // {rd, src, en, expected flags}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'hFF, 8'h00}, // 0 idle
        {1'b0, 8'h01, 8'hFF, 8'h01}, // 1 R2 lock-in bit 0
        {1'b0, 8'h00, 8'hFF, 8'h01}, // 2 R5 sticky
        {1'b0, 8'h02, 8'hFD, 8'h01}, // 3 R3 disabled source ignored
        {1'b0, 8'h04, 8'hFF, 8'h05}, // 4 R2 bit 2
        {1'b1, 8'h08, 8'hFF, 8'h05}, // 5 R4 frozen, bit 3 pending
        {1'b1, 8'h10, 8'hEF, 8'h05}, // 6 R4 R3 disabled during read
        {1'b0, 8'h00, 8'hFF, 8'h08}, // 7 R6 pending becomes visible
        {1'b0, 8'h00, 8'h00, 8'h08}, // 8 R9 disable keeps flag
        {1'b0, 8'h80, 8'hFF, 8'h08}, // 9 R7 rising edge ignored
        {1'b0, 8'h80, 8'hFF, 8'h08}, // 10 R7 high level ignored
        {1'b0, 8'h00, 8'hFF, 8'h88}, // 11 R7 falling edge
        {1'b1, 8'h00, 8'hFF, 8'h88}, // 12 R4 read
        {1'b0, 8'h00, 8'hFF, 8'h00}, // 13 R6 R8 cleared
        {1'b0, 8'h20, 8'hFF, 8'h20}, // 14 R2 bit 5
        {1'b1, 8'h40, 8'hFF, 8'h20}, // 15 R4 bit 6 pending
        {1'b0, 8'h02, 8'hFF, 8'h42}, // 16 R6 merge with same-cycle event
        {1'b1, 8'h00, 8'hFF, 8'h42}, // 17 single-cycle read
        {1'b0, 8'h00, 8'hFF, 8'h00}  // 18 R6 R8 cleared
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = '0;
    logic [7:0] en = '0;
    logic       rd = 1'b0;
    logic [7:0] flags;
    logic       irq;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_reg u_irq_flag_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .src_en_i    (en),
        .rd_active_i (rd),
        .flags_o     (flags),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic [7:0] s, input logic [7:0] e);
        rd  = r;
        src = s;
        en  = e;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flags", flags, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][24], VEC[k][23:16], VEC[k][15:8]);
            check($sformatf("R2-table row %0d flags", k), flags, VEC[k][7:0]);
            check($sformatf("R8 table row %0d irq", k), {7'b0, irq}, {7'b0, |VEC[k][7:0]});
        end

        // R2: each pulse source lands on its own bit, then a read clears it (R6)
        for (int i = 0; i < 7; i++) begin
            drive(1'b0, 8'h01 << i, 8'hFF);
            check($sformatf("R2 source %0d", i), flags, 8'h01 << i);
            drive(1'b1, 8'h00, 8'hFF);
            drive(1'b0, 8'h00, 8'hFF);
            check($sformatf("R6 clear after source %0d", i), flags, 8'h00);
        end

        // R7: chip-select bit 7 from a falling edge
        drive(1'b0, 8'h80, 8'hFF);
        check("R7 cs high", flags, 8'h00);
        drive(1'b0, 8'h00, 8'hFF);
        check("R7 cs fall", flags, 8'h80);
        check("R8 irq on cs", {7'b0, irq}, 8'h01);

        // R1: reset in mid-run clears set flags
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset flags", flags, 8'h00);
        check("R1 mid reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 8'hFF);
        check("R1 after reset", flags, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule